// File: doc/BRIEF.md
# Prescaled watchdog down counter

This block is a two-stage timeout counter. A prescaler counts clock cycles down, and each time it passes from zero back to all ones it steps a second, software-visible down counter. Software keeps the block alive by rewriting the counter before it runs out. Each such write also returns the prescaler to all ones and starts both stages. When the counter is already at zero and the prescaler wraps again, the block reports an underflow and both stages stop.

After any reset the block is inert: it is not counting, the counter reads all ones and watchdog duty is off. Software chooses the block's role once per reset through a single enable write. With the enable set, an underflow produces a one-cycle device reset request. With the enable clear, the block is a general-purpose down counter, and an underflow instead raises a sticky flag. Entering halt loads both stages with all ones, so counting restarts from the longest interval.

Top module: `wdt_down_counter`

## Requirements
- R1: After rst_ni is released, cnt_o reads 0xFF, rst_req_o and gp_uf_o are 0, and cnt_o holds its value while no counter write occurs.
- R2: A cycle with cnt_we_i high loads cnt_wdata_i into the counter, sets the prescaler to 0xFF and starts both stages. The prescaler then drops by one each clock, and the counter drops by one each time the prescaler goes from 0x00 to 0xFF, which happens every 256 clocks.
- R3: After a counter write of value N, the underflow occurs on clock edge 256*(N+1) counted from the write edge, so N+1 counter steps elapse.
- R4: Only the first arm_we_i pulse after a reset takes effect: it sets watchdog duty to arm_wdata_i (1 = watchdog, 0 = general-purpose). Later pulses are ignored until the next reset.
- R5: With watchdog duty on, an underflow drives rst_req_o high for exactly one cycle.
- R6: With watchdog duty off, an underflow sets gp_uf_o and leaves rst_req_o at 0. gp_uf_o stays set until the next counter write clears it.
- R7: After an underflow both stages stop: cnt_o stays at 0x00 and no further underflow occurs until the next counter write.
- R8: An underflow does not turn watchdog duty off, so a later counter write that runs out produces another reset request.
- R9: A cycle with halt_i high loads both stages with 0xFF and takes priority over a counter write in the same cycle. Whether the stages are counting is left as it was.
- R10: A counter write made before the underflow restarts the full interval from the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_we_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 8 | Counter write value |
| arm_we_i | input | 1 | Duty-select write strobe, honoured once per reset |
| arm_wdata_i | input | 1 | 1 selects watchdog duty, 0 selects general-purpose duty |
| halt_i | input | 1 | Halt-entry pulse |
| rst_req_o | output | 1 | One-cycle device reset request |
| gp_uf_o | output | 1 | Sticky underflow flag for general-purpose duty |
| cnt_o | output | 8 | Counter readback |

## Verification
The hardest case to reach is the exact underflow edge. A check there must trace a counter load through hundreds of prescaler cycles, with the write-once lock already set one way or the other. The stimulus table therefore pairs each duty choice with a small load value and counts the clocks to edge 256*(N+1). It checks the cycle before the underflow, the underflow cycle and the cycle after it. Further directed sequences lock the duty select and then try to change it, reload the counter after an underflow, reload it mid-interval, and send halt while the stages are counting. At each step they sample the counter 255 and 256 clocks after the event.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    ARM_OPEN = 2'd0,
    ARM_OFF  = 2'd1,
    ARM_ON   = 2'd2
  } arm_state_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned PSC_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic load_i,
  output logic wrap_o
);
  logic [PSC_W-1:0] psc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     psc_q <= '1;
    else if (load_i) psc_q <= '1;
    else if (run_i)  psc_q <= psc_q - 1'b1;
  end

  assign wrap_o = run_i && (psc_q == '0);

  AST_PSC_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && run_i) |=> !wrap_o); // R2

  AST_PSC_WRAP_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && !load_i) |=> (psc_q == '1)); // R2
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             halt_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             tick_i,
  output logic             zero_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '1;
    else if (halt_i)            cnt_q <= '1;
    else if (we_i)              cnt_q <= wdata_i;
    else if (tick_i && !zero_o) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
  assign cnt_o  = cnt_q;

  AST_CNT_HALT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> (cnt_q == '1)); // R9

  AST_CNT_STAYS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !we_i && !halt_i) |=> zero_o); // R7

  AST_CNT_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !we_i && !halt_i) |=> $stable(cnt_q)); // R1
endmodule

// File: rtl/wdt_arm_ctrl.sv
module wdt_arm_ctrl
  import wdt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic wdata_i,
  output logic en_o
);
  arm_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ARM_OPEN;
    else if (we_i && state_q == ARM_OPEN)
      state_q <= wdata_i ? ARM_ON : ARM_OFF;
  end

  assign en_o = (state_q == ARM_ON);

  AST_ARM_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ARM_OPEN) |=> (state_q == $past(state_q))); // R4
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int unsigned PSC_W = 8,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             arm_we_i,
  input  logic             arm_wdata_i,
  input  logic             halt_i,
  output logic             rst_req_o,
  output logic             gp_uf_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic run_q, wrap, cnt_zero, wd_en, uf, req_q, gp_q;

  wdt_arm_ctrl u_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (arm_we_i),
    .wdata_i (arm_wdata_i),
    .en_o    (wd_en)
  );

  wdt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_q),
    .load_i (cnt_we_i || halt_i),
    .wrap_o (wrap)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .halt_i  (halt_i),
    .we_i    (cnt_we_i),
    .wdata_i (cnt_wdata_i),
    .tick_i  (wrap),
    .zero_o  (cnt_zero),
    .cnt_o   (cnt_o)
  );

  // underflow: counter already empty when the prescaler wraps once more
  assign uf = wrap && cnt_zero && !halt_i && !cnt_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      req_q <= 1'b0;
      gp_q  <= 1'b0;
    end else begin
      req_q <= uf && wd_en;
      if (halt_i)        run_q <= run_q;
      else if (cnt_we_i) run_q <= 1'b1;
      else if (uf)       run_q <= 1'b0;
      if (cnt_we_i && !halt_i) gp_q <= 1'b0;
      else if (uf && !wd_en)   gp_q <= 1'b1;
    end
  end

  assign rst_req_o = req_q;
  assign gp_uf_o   = gp_q;

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R5

  AST_STOP_AFTER_UF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf |=> !run_q); // R7

  AST_GP_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf && !wd_en) |=> (!rst_req_o && gp_uf_o)); // R6

  AST_WD_STAYS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> wd_en); // R8
endmodule

// File: tb/wdt_down_counter_bench.sv
module wdt_down_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PSC_PERIOD = 256;
  localparam int NVEC = 5;

  typedef struct packed {
    logic       arm_we;
    logic       arm_val;
    logic [7:0] load;
    logic       exp_req;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 8'd0, 1'b0},
    '{1'b1, 1'b1, 8'd0, 1'b1},
    '{1'b1, 1'b1, 8'd2, 1'b1},
    '{1'b1, 1'b0, 8'd1, 1'b0},
    '{1'b1, 1'b1, 8'd3, 1'b1}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cnt_we_i = 1'b0, arm_we_i = 1'b0, arm_wdata_i = 1'b0, halt_i = 1'b0;
  logic [7:0] cnt_wdata_i = '0;
  logic rst_req_o, gp_uf_o;
  logic [7:0] cnt_o;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wdt_down_counter u_wdt_down_counter (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    step(2);
    rst_ni = 1'b1;
    step(1);
  endtask

  task automatic write_cnt(input logic [7:0] v);
    cnt_we_i = 1'b1; cnt_wdata_i = v;
    step(1);
    cnt_we_i = 1'b0;
  endtask

  task automatic write_arm(input logic v);
    arm_we_i = 1'b1; arm_wdata_i = v;
    step(1);
    arm_we_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    check(cnt_o == 8'hFF, "R1 cnt reset", cnt_o, 255);
    check(!rst_req_o && !gp_uf_o, "R1 outputs low", {rst_req_o, gp_uf_o}, 0);
    step(600);
    check(cnt_o == 8'hFF && !gp_uf_o, "R1 idle hold", cnt_o, 255);

    // table walk: R3 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      if (VECS[v].arm_we) write_arm(VECS[v].arm_val);
      write_cnt(VECS[v].load);
      step(PSC_PERIOD * (int'(VECS[v].load) + 1) - 1);
      check(!rst_req_o && !gp_uf_o, "R3 no event early", {rst_req_o, gp_uf_o}, 0);
      step(1);
      check(rst_req_o == VECS[v].exp_req, "R5 request at underflow", rst_req_o, VECS[v].exp_req);
      check(gp_uf_o == !VECS[v].exp_req, "R6 flag at underflow", gp_uf_o, !VECS[v].exp_req);
      step(1);
      check(!rst_req_o, "R5 one-cycle pulse", rst_req_o, 0);
      step(600);
      check(cnt_o == 8'h00 && !rst_req_o, "R7 stopped at zero", cnt_o, 0);
    end

    // R2 step cadence
    do_reset();
    write_cnt(8'd5);
    check(cnt_o == 8'd5, "R2 load", cnt_o, 5);
    step(PSC_PERIOD - 1);
    check(cnt_o == 8'd5, "R2 before first step", cnt_o, 5);
    step(1);
    check(cnt_o == 8'd4, "R2 first step", cnt_o, 4);

    // R4 later enable writes ignored
    do_reset();
    write_arm(1'b0);
    write_arm(1'b1);
    write_cnt(8'd0);
    step(PSC_PERIOD);
    check(!rst_req_o && gp_uf_o, "R4 second arm ignored", rst_req_o, 0);
    // R6 flag clears on counter write
    write_cnt(8'd1);
    check(!gp_uf_o, "R6 flag cleared by write", gp_uf_o, 0);

    // R8 enable survives underflow
    do_reset();
    write_arm(1'b1);
    write_cnt(8'd0);
    step(PSC_PERIOD);
    check(rst_req_o, "R8 first request", rst_req_o, 1);
    write_arm(1'b0);
    write_cnt(8'd0);
    step(PSC_PERIOD);
    check(rst_req_o && !gp_uf_o, "R8 second request", rst_req_o, 1);

    // R10 service restarts interval
    do_reset();
    write_arm(1'b1);
    write_cnt(8'd0);
    step(200);
    write_cnt(8'd0);
    step(PSC_PERIOD - 1);
    check(!rst_req_o, "R10 no request after service", rst_req_o, 0);
    step(1);
    check(rst_req_o, "R10 request after new interval", rst_req_o, 1);

    // R9 halt reloads both stages, beats a same-cycle write
    do_reset();
    write_cnt(8'd5);
    step(300);
    halt_i = 1'b1; cnt_we_i = 1'b1; cnt_wdata_i = 8'd7;
    step(1);
    halt_i = 1'b0; cnt_we_i = 1'b0;
    check(cnt_o == 8'hFF, "R9 halt loads counter", cnt_o, 255);
    step(PSC_PERIOD - 1);
    check(cnt_o == 8'hFF, "R9 prescaler full", cnt_o, 255);
    step(1);
    check(cnt_o == 8'hFE, "R9 still running", cnt_o, 254);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule